// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus of the I2C kind. It serves a bank of nine 8-bit control registers at indexes 00h to 08h. The system clock samples the bus clock and data lines, which means the block needs no clock of its own from the bus. The slave answers one 7-bit device address. One bit of that address comes from a strap input, so two of these slaves can share a bus.

A write transfer has three parts. The first byte carries the address and a direction bit. The second byte is a subaddress that sets the internal pointer. Every data byte after that is stored at the pointer, and the pointer then moves to the next register. A read transfer is done in two steps: a write that sets the pointer, then a repeated start followed by the address with the read bit set. The slave then returns bytes from the pointer onward until the master declines to acknowledge.

The core sees every register as a flat output vector. It also gets a one-cycle strobe for each register that is written.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset all nine registers read 00h, every write strobe is low and the slave does not pull SDA low.
- R2: The device address is 7'h54 with bit 1 replaced by the `addr_sel` strap. The slave acknowledges a first byte whose upper seven bits match this address. For any other address it does not acknowledge and changes no register.
- R3: In a write, once the subaddress is accepted, each data byte is acknowledged and stored in the register the pointer selects. The pointer then advances by one.
- R4: Every stored byte raises exactly one bit of `wr_stb` for one clock: the bit whose index equals the register written.
- R5: A subaddress above 08h is not acknowledged. This includes any byte with bit 7 set. The slave then goes idle and acknowledges none of the following bytes of that transfer.
- R6: In a write, a data byte that arrives when the pointer is past 08h is discarded and not acknowledged, and the slave goes idle.
- R7: After a repeated start and the address with R/W=1, the slave sends bytes MSB first, starting at the pointer. It advances the pointer after each byte the master acknowledges and stops sending after a byte the master does not acknowledge.
- R8: In a read, once the pointer has reached 08h, register 08h is sent again for every further byte.
- R9: A stop condition at any bit position returns the slave to idle and releases SDA. A partly received byte is discarded.
- R10: A start condition at any bit position begins a new address phase. The next byte is then taken as a device address.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Strap that sets device address bit 1 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_q | output | 72 | Register contents, register k at bits 8k+7:8k |
| wr_stb | output | 9 | One-cycle write strobe per register |

## Verification
Most faults in the sequencing state show up within one byte. A bit counter that is off by one, or a phase that is held wrong, moves the acknowledge to the wrong clock pulse. The master then sees a missing or extra acknowledge at the ninth pulse of that same byte. A pointer that is wrong keeps acknowledging correctly but produces wrong data. On a write it puts a byte into the wrong slice of `reg_q`, or raises the wrong strobe, one clock after the acknowledge slot opens. On a read it shows up in the first returned byte. A stuck drive enable is seen on SDA at the next bit the master samples, and again after the stop that ends the transfer.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_WR,
    PH_RD
  } phase_t;

  // device address: strap replaces bit 1 of the base
  function automatic logic [6:0] dev_addr(input logic [6:0] base, input logic strap);
    return {base[6:2], strap, base[0]};
  endfunction

  // true when an index lies inside the register bank
  function automatic logic in_bank(input logic [7:0] idx, input logic [7:0] last);
    return idx <= last;
  endfunction

  // read pointer advance that sticks at the last register
  function automatic logic [7:0] sat_inc(input logic [7:0] p, input logic [7:0] last);
    return (p >= last) ? last : p + 8'd1;
  endfunction

  // read index, never beyond the last register
  function automatic logic [7:0] clamp_idx(input logic [7:0] p, input logic [7:0] last);
    return (p > last) ? last : p;
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  // index 1 = SCL, index 0 = SDA; two meta stages plus one history stage
  logic [1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 2'b11;
      sync_q <= 2'b11;
      hist_q <= 2'b11;
    end else begin
      meta_q <= {scl_i, sda_i};
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign scl_s     = sync_q[1];
  assign sda_s     = sync_q[0];
  assign scl_rise  =  sync_q[1] & ~hist_q[1];
  assign scl_fall  = ~sync_q[1] &  hist_q[1];
  assign start_evt =  sync_q[1] & hist_q[1] &  hist_q[0] & ~sync_q[0];
  assign stop_evt  =  sync_q[1] & hist_q[1] & ~hist_q[0] &  sync_q[0];
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
  parameter int NUM_REGS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] reg_q,
  output logic [NUM_REGS-1:0]   wr_stb
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r_q;
    assign wr_stb[g] = wr_en && (wr_idx == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         r_q <= '0;
      else if (wr_stb[g]) r_q <= wr_data;
    end
    assign reg_q[g*8 +: 8] = r_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == 8'(i)) rd_data = reg_q[i*8 +: 8];
  end
endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter int         NUM_REGS  = 9,
  parameter logic [6:0] BASE_ADDR = 7'h54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       strap,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe,
  output logic       busy,
  output logic       in_addr,
  output logic       sub_reject
);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  phase_t     ph;
  logic [3:0] bitcnt;
  logic [7:0] rx_q, tx_q, ptr;
  logic       rd_dir, m_ack;

  wire byte_done = scl_fall && (bitcnt == 4'd8);
  wire slot_done = scl_fall && (bitcnt == 4'd9);

  assign rd_idx     = clamp_idx(ptr, LAST);
  assign busy       = (ph != PH_IDLE);
  assign in_addr    = (ph == PH_ADDR);
  assign sub_reject = byte_done && (ph == PH_SUB) && !in_bank(rx_q, LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; bitcnt <= '0; rx_q <= '0; tx_q <= '0; ptr <= '0;
      rd_dir <= 1'b0; m_ack <= 1'b0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        ph <= PH_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        ph <= PH_IDLE; sda_oe <= 1'b0;
      end else if (ph != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            if (ph != PH_RD) rx_q <= {rx_q[6:0], sda_s};
          end else if (ph == PH_RD) begin
            m_ack <= !sda_s;
            if (!sda_s) ptr <= sat_inc(ptr, LAST);
          end
          bitcnt <= bitcnt + 4'd1;
        end else if (byte_done) begin
          unique case (ph)
            PH_ADDR:
              if (rx_q[7:1] == dev_addr(BASE_ADDR, strap)) begin
                sda_oe <= 1'b1; rd_dir <= rx_q[0];
              end else begin
                ph <= PH_IDLE; sda_oe <= 1'b0;
              end
            PH_SUB:
              if (in_bank(rx_q, LAST)) begin
                sda_oe <= 1'b1; ptr <= rx_q;
              end else begin
                ph <= PH_IDLE; sda_oe <= 1'b0;
              end
            PH_WR:
              if (in_bank(ptr, LAST)) begin
                sda_oe <= 1'b1; wr_en <= 1'b1; wr_idx <= ptr; wr_data <= rx_q;
                ptr <= ptr + 8'd1;
              end else begin
                ph <= PH_IDLE; sda_oe <= 1'b0;
              end
            default: sda_oe <= 1'b0;  // read: hand the line to the master
          endcase
        end else if (slot_done) begin
          bitcnt <= '0;
          unique case (ph)
            PH_ADDR:
              if (rd_dir) begin
                ph <= PH_RD; tx_q <= rd_data; sda_oe <= !rd_data[7];
              end else begin
                ph <= PH_SUB; sda_oe <= 1'b0;
              end
            PH_SUB: begin ph <= PH_WR; sda_oe <= 1'b0; end
            PH_WR:  sda_oe <= 1'b0;
            default:
              if (m_ack) begin
                tx_q <= rd_data; sda_oe <= !rd_data[7];
              end else begin
                ph <= PH_IDLE; sda_oe <= 1'b0;
              end
          endcase
        end else if (scl_fall && ph == PH_RD) begin
          tx_q   <= {tx_q[6:0], 1'b0};
          sda_oe <= !tx_q[6];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         NUM_REGS  = 9,
  parameter logic [6:0] BASE_ADDR = 7'h54
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_q,
  output logic [NUM_REGS-1:0]   wr_stb
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_en, busy, in_addr, sub_reject;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  i2c_rb_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_rb_fsm #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(addr_sel), .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe), .busy(busy),
    .in_addr(in_addr), .sub_reject(sub_reject)
  );

  i2c_rb_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .reg_q(reg_q), .wr_stb(wr_stb)
  );
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk #(
  parameter int NUM_REGS = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_fall,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  sub_reject,
  input logic                  busy,
  input logic                  in_addr,
  input logic                  sda_oe,
  input logic [NUM_REGS-1:0]   wr_stb,
  input logic [NUM_REGS*8-1:0] reg_q
);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  p_drive_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall));

  p_stb_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  p_hold_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb == '0) |=> $stable(reg_q));

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy);

  p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> in_addr);

  p_bad_sub_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reject |=> !busy);
endmodule

bind i2c_regbank_slave i2c_rb_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .sub_reject(sub_reject), .busy(busy),
  .in_addr(in_addr), .sda_oe(sda_oe), .wr_stb(wr_stb), .reg_q(reg_q)
);

// File: tb/i2c_regbank_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb;
  localparam int NR = 9;
  localparam int Q  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_oe;
  logic [NR*8-1:0] reg_q;
  logic [NR-1:0]   wr_stb;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regbank_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(strap), .sda_oe(sda_oe), .reg_q(reg_q), .wr_stb(wr_stb)
  );

  int nvec = 0, nfail = 0;
  logic [7:0] mdl [NR];
  int exp_cnt [NR];
  int obs_cnt [NR];
  logic drive_bad = 1'b0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NR; i++) if (wr_stb[i]) obs_cnt[i]++;
      if (wr_stb != 0 && (wr_stb & (wr_stb - 1)) != 0) drive_bad = 1'b1;
      if (sda_oe !== oe_prev && scl) drive_bad = 1'b1;
    end
    oe_prev = sda_oe;
  end

  function automatic logic [6:0] my_addr(input logic s);
    return 7'h54 | {5'd0, s, 1'b0};
  endfunction

  function automatic logic [NR*8-1:0] flat_model();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [NR*8-1:0] act, input logic [NR*8-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; wq(); scl = 1'b1; wq(); r = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_start(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq(); endtask
  task automatic bus_stop();  sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); b[i] = r; end
    bit_io(!give_ack, r);
  endtask

  task automatic check_state(input string req);
    chk(req, reg_q, flat_model());
    chk(req, sda_oe, 1'b0);
    for (int i = 0; i < NR; i++) chk("R4", obs_cnt[i], exp_cnt[i]);
  endtask

  // write transfer; expectations computed from the requirements
  task automatic wr_body(input logic [6:0] a, input logic [7:0] sub, input int n);
    logic ack, alive, e;
    int p;
    wr_byte({a, 1'b0}, ack);
    alive = (a == my_addr(strap));
    chk("R2", ack, alive);
    wr_byte(sub, ack);
    e = alive && (sub < 8'd9);
    chk(sub < 8'd9 ? "R3" : "R5", ack, e);
    alive = e; p = sub;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'($urandom);
      wr_byte(d, ack);
      e = alive && (p < NR);
      chk(!alive ? "R5" : (p < NR ? "R3" : "R6"), ack, e);
      if (e) begin mdl[p] = d; exp_cnt[p]++; p++; end
      else alive = 1'b0;
    end
    bus_stop();
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] sub, input int n);
    bus_start();
    wr_body(a, sub, n);
    check_state("R3");
  endtask

  task automatic rd_txn(input logic [7:0] sub, input int n);
    logic ack;
    logic [7:0] d;
    int p;
    bus_start();
    wr_byte({my_addr(strap), 1'b0}, ack); chk("R7", ack, 1'b1);
    wr_byte(sub, ack);                    chk("R7", ack, 1'b1);
    bus_start();
    wr_byte({my_addr(strap), 1'b1}, ack); chk("R7", ack, 1'b1);
    p = sub;
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, d);
      chk(p >= NR - 1 && k > 0 ? "R8" : "R7", d, mdl[p > NR - 1 ? NR - 1 : p]);
      if (p < NR - 1) p++;
    end
    bus_stop();
    chk("R7", sda_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic r;
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) begin mdl[i] = 8'h00; exp_cnt[i] = 0; obs_cnt[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", reg_q, '0);
    chk("R1", sda_oe, 1'b0);
    chk("R1", wr_stb, '0);

    // R3/R4: plain write runs
    wr_txn(my_addr(0), 8'd0, 9);
    wr_txn(my_addr(0), 8'd2, 3);
    // R2: wrong address, and strap select
    wr_txn(7'h55, 8'd1, 2);
    strap = 1'b1;
    wr_txn(my_addr(0), 8'd1, 2);
    wr_txn(my_addr(1), 8'd1, 2);
    strap = 1'b0;
    // R5: invalid subaddresses
    wr_txn(my_addr(0), 8'h09, 2);
    wr_txn(my_addr(0), 8'h80, 2);
    // R6: run past the last register
    wr_txn(my_addr(0), 8'd7, 4);
    // R7/R8: reads with clamp
    rd_txn(8'd0, 3);
    rd_txn(8'd7, 5);

    // R9: stop in the middle of a data byte
    bus_start();
    wr_byte({my_addr(0), 1'b0}, ack); chk("R9", ack, 1'b1);
    wr_byte(8'd2, ack);               chk("R9", ack, 1'b1);
    for (int i = 0; i < 4; i++) bit_io(1'b1, r);
    bus_stop();
    check_state("R9");

    // R10: start in the middle of a data byte, then a full write
    bus_start();
    wr_byte({my_addr(0), 1'b0}, ack); chk("R10", ack, 1'b1);
    wr_byte(8'd3, ack);               chk("R10", ack, 1'b1);
    for (int i = 0; i < 3; i++) bit_io(1'b0, r);
    bus_start();
    wr_body(my_addr(0), 8'd4, 1);
    check_state("R10");

    // random mix
    for (int it = 0; it < 30; it++) begin
      strap = 1'($urandom);
      if ($urandom_range(0, 2) == 0)
        rd_txn(8'($urandom_range(0, 8)), $urandom_range(1, 4));
      else if ($urandom_range(0, 5) == 0)
        wr_txn(my_addr(!strap), 8'($urandom_range(0, 8)), 2);
      else
        wr_txn(my_addr(strap), 8'($urandom_range(0, 10)), $urandom_range(1, 4));
    end

    chk("R11", drive_bad, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule